// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It walks a two-level table that lives in memory. The upper index field picks an entry in a directory, and that entry names a second-level table. The middle index field picks a page entry in that table. The page entry supplies the page frame, and the low bits of the virtual address pass through unchanged as the byte offset. Entries are read one at a time through a simple request/response read port. Any fetch may complete with an error response.

A walk ends with exactly one outcome, reported in a single-cycle result pulse:
- a translated physical address;
- a page fault that carries the virtual address and the access direction;
- a bus error that carries the same fault information.

A page fault has three causes: an invalid directory entry, an invalid page entry, or a missing permission for the access direction. The walker takes one walk at a time. A stall input keeps it from accepting new walks, and a walk already in flight runs to completion.

Top module: `ptw_top`

## Requirements
- R1: After reset `reqReady` is 1 (with `stall` low), and `respValid` and `memReqValid` are 0.
- R2: `reqReady` is 1 only while the walker is idle and `stall` is 0. A request offered while stalled is not taken and issues no fetch. A stall raised during a walk does not stop that walk.
- R3: The first fetch reads the directory entry at address {`dirBase`[31:12], 12'h000} + 4 × `reqVaddr`[31:22]. The low 12 bits of `dirBase` are ignored.
- R4: The second fetch reads the page entry at address {entry[31:12], 12'h000} + 4 × `reqVaddr`[21:12], where entry is the directory entry returned by the first fetch.
- R5: A directory entry with bit 0 (valid) clear ends the walk with a page fault, and no second fetch is made. Bits 11:1 of a directory entry are ignored.
- R6: A page entry with bit 0 (valid) clear ends the walk with a page fault.
- R7: A read (`reqWrite`=0) needs page-entry bit 1 set, and a write (`reqWrite`=1) needs page-entry bit 2 set. If the needed bit is clear, the walk ends with a page fault.
- R8: A successful walk returns `respPaddr` = {page entry[31:12], `reqVaddr`[11:0]}. Page-entry bits 11:3 do not affect the result.
- R9: An error response on either fetch ends the walk with `respBusErr`=1 and `respFault`=0. On any fault or bus error, `respFaultAddr` equals the request's virtual address and `respFaultWrite` equals its direction.
- R10: Each walk produces one `respValid` pulse one cycle long. At most one of `respFault` and `respBusErr` is set in that pulse. The walker is idle again in the next cycle.
- R11: `memReqValid` stays high, with a stable `memReqAddr`, until the cycle in which `memRspValid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 32 | Directory base address; only bits 31:12 are used |
| stall | input | 1 | Holds off acceptance of new walks |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker can take a request this cycle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| memReqValid | output | 1 | Entry fetch outstanding |
| memReqAddr | output | 32 | Byte address of the entry being fetched |
| memRspValid | input | 1 | Fetch response present |
| memRspData | input | 32 | Fetched 32-bit entry |
| memRspErr | input | 1 | Fetch completed with an error |
| respValid | output | 1 | One-cycle pulse carrying the walk result |
| respPaddr | output | 32 | Translated physical address |
| respFault | output | 1 | Walk ended in a page fault |
| respBusErr | output | 1 | Walk ended in a bus error |
| respFaultAddr | output | 32 | Virtual address of the faulting walk |
| respFaultWrite | output | 1 | Direction of the faulting walk |

## Verification
The bench builds the walker with its default split: 10-bit directory index, 10-bit table index and 12-bit offset. With these values the vectors can use the extreme index values 0 and 1023 at both levels, and an offset of all ones. They can also set every reserved and attribute bit in the entries and check that only the valid and permission bits matter. A scripted memory answers each fetch after a latency of one to three cycles. It checks every fetch address against the expected index arithmetic, which exercises the held-request rule. Injected error responses at each level reach the bus-error path.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int EntryValidBit = 0;
  localparam int ReadBit       = 1;
  localparam int WriteBit      = 2;
  localparam int EntryBytesLog2 = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_DIR,
    ST_FETCH_PTE,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic captureReq;
    logic selPte;
    logic captureTbl;
    logic capturePage;
    logic flagFault;
    logic flagBusErr;
  } walkStrobes_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stall,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  logic         memRspErr,
  input  logic         entryValid,
  input  logic         permOk,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         respValid,
  output walkStrobes_t strobes
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    strobes.selPte = (state == ST_FETCH_PTE);
    unique case (state)
      ST_IDLE: begin
        if (reqValid && !stall) begin
          strobes.captureReq = 1'b1;
          stateNext = ST_FETCH_DIR;
        end
      end
      ST_FETCH_DIR: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strobes.flagBusErr = 1'b1;
            stateNext = ST_FAULT;
          end else if (!entryValid) begin
            strobes.flagFault = 1'b1;
            stateNext = ST_FAULT;
          end else begin
            strobes.captureTbl = 1'b1;
            stateNext = ST_FETCH_PTE;
          end
        end
      end
      ST_FETCH_PTE: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strobes.flagBusErr = 1'b1;
            stateNext = ST_FAULT;
          end else if (!(entryValid && permOk)) begin
            strobes.flagFault = 1'b1;
            stateNext = ST_FAULT;
          end else begin
            strobes.capturePage = 1'b1;
            stateNext = ST_DONE;
          end
        end
      end
      ST_DONE, ST_FAULT: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE) && !stall;
  assign memReqValid = (state == ST_FETCH_DIR) || (state == ST_FETCH_PTE);
  assign respValid   = (state == ST_DONE) || (state == ST_FAULT);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFF_W     = 12,
  localparam int ADDR_W   = DIR_IDX_W + TBL_IDX_W + OFF_W,
  localparam int BASE_W   = ADDR_W - OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      strobes,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              entryValid,
  output logic              permOk,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              respFault,
  output logic              respBusErr,
  output logic [ADDR_W-1:0] respFaultAddr,
  output logic              respFaultWrite
);
  logic [ADDR_W-1:0]    vaddrQ;
  logic                 writeQ;
  logic [BASE_W-1:0]    dirBaseQ, tblBaseQ, pageBaseQ;
  logic                 faultQ, busErrQ;
  logic [DIR_IDX_W-1:0] dirIdx;
  logic [TBL_IDX_W-1:0] tblIdx;
  logic [ADDR_W-1:0]    dirEntryAddr, pteEntryAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      writeQ    <= 1'b0;
      dirBaseQ  <= '0;
      tblBaseQ  <= '0;
      pageBaseQ <= '0;
      faultQ    <= 1'b0;
      busErrQ   <= 1'b0;
    end else begin
      if (strobes.captureReq) begin
        vaddrQ   <= reqVaddr;
        writeQ   <= reqWrite;
        dirBaseQ <= dirBase[ADDR_W-1:OFF_W];
        faultQ   <= 1'b0;
        busErrQ  <= 1'b0;
      end
      if (strobes.captureTbl)  tblBaseQ  <= memRspData[ADDR_W-1:OFF_W];
      if (strobes.capturePage) pageBaseQ <= memRspData[ADDR_W-1:OFF_W];
      if (strobes.flagFault)   faultQ    <= 1'b1;
      if (strobes.flagBusErr)  busErrQ   <= 1'b1;
    end
  end

  assign dirIdx = vaddrQ[ADDR_W-1 -: DIR_IDX_W];
  assign tblIdx = vaddrQ[OFF_W +: TBL_IDX_W];

  assign dirEntryAddr = {dirBaseQ, {OFF_W{1'b0}}} + (ADDR_W'(dirIdx) << EntryBytesLog2);
  assign pteEntryAddr = {tblBaseQ, {OFF_W{1'b0}}} + (ADDR_W'(tblIdx) << EntryBytesLog2);
  assign memReqAddr   = strobes.selPte ? pteEntryAddr : dirEntryAddr;

  assign entryValid = memRspData[EntryValidBit];
  assign permOk     = writeQ ? memRspData[WriteBit] : memRspData[ReadBit];

  assign respPaddr      = {pageBaseQ, vaddrQ[OFF_W-1:0]};
  assign respFault      = faultQ;
  assign respBusErr     = busErrQ;
  assign respFaultAddr  = vaddrQ;
  assign respFaultWrite = writeQ;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFF_W     = 12,
  localparam int ADDR_W   = DIR_IDX_W + TBL_IDX_W + OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              stall,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              respValid,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              respFault,
  output logic              respBusErr,
  output logic [ADDR_W-1:0] respFaultAddr,
  output logic              respFaultWrite
);
  walkStrobes_t strobes;
  logic entryValid, permOk;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .reqValid(reqValid),
    .memRspValid(memRspValid), .memRspErr(memRspErr),
    .entryValid(entryValid), .permOk(permOk),
    .reqReady(reqReady), .memReqValid(memReqValid),
    .respValid(respValid), .strobes(strobes)
  );

  ptw_datapath #(.DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dirBase(dirBase),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .entryValid(entryValid), .permOk(permOk),
    .respPaddr(respPaddr), .respFault(respFault), .respBusErr(respBusErr),
    .respFaultAddr(respFaultAddr), .respFaultWrite(respFaultWrite)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFF_W     = 12,
  localparam int ADDR_W   = DIR_IDX_W + TBL_IDX_W + OFF_W
)(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] dirBase,
  input logic              stall,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              reqWrite,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [ADDR_W-1:0] memRspData,
  input logic              memRspErr,
  input logic              respValid,
  input logic              respFault,
  input logic              respBusErr,
  input logic [ADDR_W-1:0] respFaultAddr,
  input logic              respFaultWrite
);
  logic [ADDR_W-1:0] capVaddr;
  logic              capWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capVaddr <= '0;
      capWrite <= 1'b0;
    end else if (reqValid && reqReady) begin
      capVaddr <= reqVaddr;
      capWrite <= reqWrite;
    end
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!stall && !memReqValid && !respValid));

  a_r3_dir_base: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memReqValid &&
      memReqAddr[ADDR_W-1:OFF_W] == $past(dirBase[ADDR_W-1:OFF_W])));

  // R5 and R6: an invalid entry at either level ends the walk in a fault
  a_r5_invalid_faults: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRspValid && !memRspErr && !memRspData[0]) |=>
      (respValid && respFault && !memReqValid));

  a_r9_fault_info: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && (respFault || respBusErr)) |->
      (respFaultAddr == capVaddr && respFaultWrite == capWrite));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !(respFault && respBusErr));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> (memReqValid && $stable(memReqAddr)));
endmodule

bind ptw_top ptw_checker #(.DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
  typedef struct packed {
    logic [31:0] vaddr;
    logic        wr;
    logic [31:0] dte;
    logic [31:0] pte;
    logic        dteErr;
    logic        pteErr;
    logic [1:0]  lat;
    logic [1:0]  kind;   // 0 ok, 1 page fault, 2 bus error
    logic [31:0] paddr;
  } vec_t;

  localparam logic [31:0] DIR_BASE = 32'h0010_0ABC;
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_1234, 1'b0, 32'h0020_0001, 32'h1234_5003, 1'b0, 1'b0, 2'd1, 2'd0, 32'h1234_5234}, // R8 read ok
    '{32'hFFC0_0FFF, 1'b1, 32'h0030_0FFF, 32'hABCD_E1FD, 1'b0, 1'b0, 2'd2, 2'd0, 32'hABCD_EFFF}, // R5/R8 reserved ignored
    '{32'h0080_0010, 1'b0, 32'h0020_0000, 32'h1111_1003, 1'b0, 1'b0, 2'd3, 2'd1, 32'h0},         // R5 dte invalid
    '{32'h003F_F800, 1'b1, 32'h0040_0001, 32'h5555_5006, 1'b0, 1'b0, 2'd1, 2'd1, 32'h0},         // R6 pte invalid
    '{32'h0040_2000, 1'b0, 32'h0020_0001, 32'h1111_1005, 1'b0, 1'b0, 2'd2, 2'd1, 32'h0},         // R7 read no perm
    '{32'h0040_3000, 1'b1, 32'h0020_0001, 32'h2222_2003, 1'b0, 1'b0, 2'd1, 2'd1, 32'h0},         // R7 write no perm
    '{32'h0C00_0000, 1'b1, 32'h0020_0001, 32'h3333_3007, 1'b1, 1'b0, 2'd3, 2'd2, 32'h0},         // R9 dir bus error
    '{32'h0040_4444, 1'b0, 32'h0020_0001, 32'h3333_3007, 1'b0, 1'b1, 2'd2, 2'd2, 32'h0},         // R9 pte bus error
    '{32'h1234_5678, 1'b1, 32'h0050_0001, 32'h7777_7007, 1'b0, 1'b0, 2'd1, 2'd0, 32'h7777_7678}  // R8 write ok
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = DIR_BASE;
  logic        stall = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        respValid;
  logic [31:0] respPaddr;
  logic        respFault;
  logic        respBusErr;
  logic [31:0] respFaultAddr;
  logic        respFaultWrite;

  int   nChecks = 0;
  int   nFails  = 0;
  int   nFetch  = 0;
  vec_t cur;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  ptw_top dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expDirAddr(input vec_t v);
    return {DIR_BASE[31:12], 12'h000} + {20'h0, v.vaddr[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] expPteAddr(input vec_t v);
    return {v.dte[31:12], 12'h000} + {20'h0, v.vaddr[21:12], 2'b00};
  endfunction

  // scripted memory: answers each fetch and checks its address
  initial begin
    forever begin
      @(negedge clk);
      if (memRspValid) begin
        memRspValid = 1'b0;
        memRspErr   = 1'b0;
      end else if (memReqValid) begin
        nFetch++;
        if (nFetch == 1) begin
          chk(memReqAddr == expDirAddr(cur), "R3 dir fetch addr", memReqAddr, expDirAddr(cur));
          memRspData = cur.dte;
          memRspErr  = cur.dteErr;
        end else begin
          chk(memReqAddr == expPteAddr(cur), "R4 pte fetch addr", memReqAddr, expPteAddr(cur));
          memRspData = cur.pte;
          memRspErr  = cur.pteErr;
        end
        repeat (int'(cur.lat) - 1) @(negedge clk);
        memRspValid = 1'b1;
      end
    end
  end

  task automatic waitResp();
    int t = 0;
    while (!respValid && t < 60) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic checkResult(input vec_t v);
    int expFetch = (v.dteErr || !v.dte[0]) ? 1 : 2;
    chk(respValid, "R10 result pulse", 32'(respValid), 32'd1);
    chk(respFault == (v.kind == 2'd1), "R5/R6/R7 fault flag", 32'(respFault), 32'(v.kind == 2'd1));
    chk(respBusErr == (v.kind == 2'd2), "R9 bus error flag", 32'(respBusErr), 32'(v.kind == 2'd2));
    if (v.kind == 2'd0) begin
      chk(respPaddr == v.paddr, "R8 physical address", respPaddr, v.paddr);
    end else begin
      chk(respFaultAddr == v.vaddr, "R9 fault address", respFaultAddr, v.vaddr);
      chk(respFaultWrite == v.wr, "R9 fault direction", 32'(respFaultWrite), 32'(v.wr));
    end
    chk(nFetch == expFetch, "R5 fetch count", nFetch, expFetch);
  endtask

  task automatic runWalk(input vec_t v);
    cur = v;
    nFetch = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = v.vaddr;
    reqWrite = v.wr;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    waitResp();
    checkResult(v);
    @(negedge clk);
    chk(!respValid, "R10 pulse one cycle", 32'(respValid), 32'd0);
    chk(reqReady, "R10 idle after result", 32'(reqReady), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady, "R1 ready after reset", 32'(reqReady), 32'd1);
    chk(!respValid, "R1 no result after reset", 32'(respValid), 32'd0);
    chk(!memReqValid, "R1 no fetch after reset", 32'(memReqValid), 32'd0);

    for (int i = 0; i < NVEC; i++) runWalk(VECS[i]);

    // R2: stalled request is not taken; stall mid-walk does not stop the walk
    cur = VECS[0];
    nFetch = 0;
    @(negedge clk);
    stall = 1'b1;
    reqValid = 1'b1;
    reqVaddr = VECS[0].vaddr;
    reqWrite = VECS[0].wr;
    repeat (5) @(negedge clk);
    chk(!reqReady, "R2 not ready while stalled", 32'(reqReady), 32'd0);
    chk(nFetch == 0 && !memReqValid, "R2 no fetch while stalled", nFetch, 0);
    stall = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    stall = 1'b1;
    waitResp();
    checkResult(VECS[0]);
    @(negedge clk);
    chk(!reqReady, "R2 ready held low by stall", 32'(reqReady), 32'd0);
    stall = 1'b0;
    #0.1;
    chk(reqReady, "R2 ready after stall release", 32'(reqReady), 32'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule